// File: doc/BRIEF.md
# Register Decrement Execute Unit

This block is a single-cycle execute stage for an 8-bit processor core. It holds a file of 32 eight-bit working registers, an 8-bit status register and a program counter. It accepts one 16-bit instruction word per clock when a valid strobe is high.

When the word encodes a register decrement, the unit reads the selected register and writes back that value minus one. It recomputes the four arithmetic flags that describe the result and leaves every other status bit alone. This lets the instruction count loop iterations between the steps of a multi-byte add or subtract without disturbing the carry chain.

Any other word behaves as a no-operation that only moves the program counter forward. Debug read ports expose one selectable register, the status byte and the program counter.

Top module: `dec_exec_unit`

## Requirements
- R1: A valid word whose bits [15:9] are 1001010 and whose bits [3:0] are 1010 is a decrement, and bits [8:4] pick the target register 0..31; only that register is written.
- R2: The target register receives its old value minus one, wrapping modulo 256 (0x00 becomes 0xFF).
- R3: A decrement leaves status bits C (bit 0), H (bit 5), T (bit 6) and I (bit 7) at their previous values, whether they were 0 or 1.
- R4: Status bit V (bit 3) is set after a decrement exactly when the old value was 0x80, and cleared otherwise.
- R5: Status bit N (bit 2) equals bit 7 of the decrement result.
- R6: Status bit Z (bit 1) is set when the decrement result is 0x00, and cleared otherwise.
- R7: Status bit S (bit 4) equals the XOR of the new N and the new V.
- R8: Every valid word, decrement or not, adds one to the program counter in the same clock.
- R9: A valid word that is not a decrement changes no register and no status bit.
- R10: While the valid strobe is low, registers, status and program counter hold.
- R11: A synchronous active-high reset clears the program counter and all 32 registers, and loads the status register with the RESET_STATUS parameter (default 0x00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| dbg_reg_sel | input | 5 | Register index for the debug read port |
| dbg_reg_data | output | 8 | Current content of the selected register |
| dbg_status | output | 8 | Current status register |
| dbg_pc | output | 16 | Current program counter |

## Verification
The bench builds two copies of the unit from one instruction stream. The first uses the default reset status of 0x00. The second uses RESET_STATUS = 0xE1, which starts it with carry, half-carry, T and interrupt bits set. Because of the second copy, the requirement that these bits are kept can be checked for both polarities without a load path. The 8-bit data width and 16-bit counter width make the full modulo-256 wrap reachable within a few hundred cycles. This covers 0x80 to 0x7F, 0x00 to 0xFF and a count from 0x10 down to zero.

// File: rtl/dec_pkg.sv
package dec_pkg;
    // status register bit positions
    localparam int SR_C = 0;
    localparam int SR_Z = 1;
    localparam int SR_N = 2;
    localparam int SR_V = 3;
    localparam int SR_S = 4;
    localparam int SR_H = 5;
    localparam int SR_T = 6;
    localparam int SR_I = 7;

    localparam int SR_W    = 8;
    localparam int INSTR_W = 16;
    localparam int SEL_W   = 5;

    // fixed fields of the decrement encoding
    localparam logic [6:0] DEC_OP_HI = 7'b1001010;
    localparam logic [3:0] DEC_OP_LO = 4'b1010;
endpackage

// File: rtl/dec_decode.sv
module dec_decode
    import dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_dec,
    output logic [SEL_W-1:0]   tgt_idx
);
    always_comb begin
        is_dec  = (instr[15:9] == DEC_OP_HI) && (instr[3:0] == DEC_OP_LO);
        tgt_idx = instr[8:4];
    end
endmodule

// File: rtl/dec_flag_calc.sv
module dec_flag_calc
    import dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [SR_W-1:0]   sr_in,
    output logic [DATA_W-1:0] result,
    output logic [SR_W-1:0]   sr_out
);
    localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic ovf, neg, zer;

    always_comb begin
        result = operand - ONE;
        ovf    = (operand == MIN_NEG);
        neg    = result[DATA_W-1];
        zer    = (result == '0);
        sr_out       = sr_in;
        sr_out[SR_V] = ovf;
        sr_out[SR_N] = neg;
        sr_out[SR_Z] = zer;
        sr_out[SR_S] = neg ^ ovf;
    end
endmodule

// File: rtl/dec_exec_unit.sv
module dec_exec_unit
    import dec_pkg::*;
#(
    parameter int              DATA_W       = 8,
    parameter int              PC_W         = 16,
    parameter logic [SR_W-1:0] RESET_STATUS = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [SEL_W-1:0]    dbg_reg_sel,
    output logic [DATA_W-1:0]   dbg_reg_data,
    output logic [SR_W-1:0]     dbg_status,
    output logic [PC_W-1:0]     dbg_pc
);
    localparam int NUM_REGS = 1 << SEL_W;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] rf;
        logic [SR_W-1:0]                 sr;
        logic [PC_W-1:0]                 pc;
    } state_t;

    state_t st_d, st_q;

    logic              hit;
    logic [SEL_W-1:0]  tgt_idx;
    logic [DATA_W-1:0] new_val;
    logic [SR_W-1:0]   new_sr;

    dec_decode u_decode (
        .instr   (instr),
        .is_dec  (hit),
        .tgt_idx (tgt_idx)
    );

    dec_flag_calc #(.DATA_W(DATA_W)) u_flags (
        .operand (st_q.rf[tgt_idx]),
        .sr_in   (st_q.sr),
        .result  (new_val),
        .sr_out  (new_sr)
    );

    always_comb begin
        st_d = st_q;
        if (instr_valid) begin
            st_d.pc = st_q.pc + PC_W'(1);
            if (hit) begin
                st_d.rf[tgt_idx] = new_val;
                st_d.sr          = new_sr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rf <= '0;
            st_q.sr <= RESET_STATUS;
            st_q.pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_reg_data = st_q.rf[dbg_reg_sel];
    assign dbg_status   = st_q.sr;
    assign dbg_pc       = st_q.pc;
endmodule

// File: rtl/dec_exec_chk.sv
module dec_exec_chk
    import dec_pkg::*;
#(
    parameter int PC_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [SR_W-1:0]    status,
    input logic [PC_W-1:0]    pc
);
    logic dec_word;
    assign dec_word = (instr[15:12] == 4'b1001) && (instr[11:9] == 3'b010)
                      && (instr[3:0] == 4'b1010);

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> pc == $past(pc) + PC_W'(1)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(status) && $stable(pc)); // R10

    AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> $stable(status[SR_C]) && $stable(status[SR_H])
                        && $stable(status[SR_T]) && $stable(status[SR_I])); // R3

    AST_OTHER_NOP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !dec_word) |=> $stable(status)); // R9

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec_word) |=> status[SR_S] == (status[SR_N] ^ status[SR_V])); // R7

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec_word) |=> !(status[SR_Z] && status[SR_N])); // R6
endmodule

bind dec_exec_unit dec_exec_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .status      (dbg_status),
    .pc          (dbg_pc)
);

// File: tb/tb_dec_exec_unit.sv
`timescale 1ns/1ps
module tb_dec_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [4:0]  sel = 5'd0;
    logic [7:0]  rd_a, rd_b, sr_a, sr_b;
    logic [15:0] pc_a, pc_b;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference: index 0 = default instance, 1 = preset-status instance
    int m_reg [2][32];
    int m_sr  [2];
    int m_pc  [2];
    int rr_idx = 0;

    always #10 clk = ~clk; // 50 MHz

    dec_exec_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .dbg_reg_sel(sel), .dbg_reg_data(rd_a), .dbg_status(sr_a), .dbg_pc(pc_a));

    dec_exec_unit #(.RESET_STATUS(8'hE1)) dut_c (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .dbg_reg_sel(sel), .dbg_reg_data(rd_b), .dbg_status(sr_b), .dbg_pc(pc_b));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] dec_op(input int r);
        return {7'b1001010, 5'(r), 4'b1010};
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 32; i++) m_reg[k][i] = 0;
            m_pc[k] = 0;
        end
        m_sr[0] = 8'h00;
        m_sr[1] = 8'hE1;
    endtask

    task automatic model_apply(input logic v, input logic [15:0] w);
        if (!v) return;
        for (int k = 0; k < 2; k++) begin
            m_pc[k] = (m_pc[k] + 1) % 65536;
            if (w[15:9] == 7'b1001010 && w[3:0] == 4'b1010) begin
                int d, o, r, fv, fn, fz;
                d = int'(w[8:4]);
                o = m_reg[k][d];
                r = (o + 255) % 256;
                m_reg[k][d] = r;
                fv = (o == 128) ? 1 : 0;
                fn = (r >= 128) ? 1 : 0;
                fz = (r == 0) ? 1 : 0;
                m_sr[k] = (m_sr[k] & 8'hE1) | (fz << 1) | (fn << 2) | (fv << 3)
                          | ((fn ^ fv) << 4);
            end
        end
    endtask

    // per-cycle comparison against the model
    task automatic compare_all();
        chk(sr_a == 8'(m_sr[0]), "R3/R4/R5/R6/R7 status dut", int'(sr_a), m_sr[0]);
        chk(sr_b == 8'(m_sr[1]), "R3/R4/R5/R6/R7 status dut_c", int'(sr_b), m_sr[1]);
        chk(pc_a == 16'(m_pc[0]), "R8 pc dut", int'(pc_a), m_pc[0]);
        chk(pc_b == 16'(m_pc[1]), "R8 pc dut_c", int'(pc_b), m_pc[1]);
        sel = 5'(rr_idx);
        #1;
        chk(rd_a == 8'(m_reg[0][rr_idx]), "R1/R2 reg dut", int'(rd_a), m_reg[0][rr_idx]);
        chk(rd_b == 8'(m_reg[1][rr_idx]), "R1/R2 reg dut_c", int'(rd_b), m_reg[1][rr_idx]);
        rr_idx = (rr_idx + 1) % 32;
    endtask

    // drive just after a falling edge, return at the next falling edge
    task automatic step(input logic v, input logic [15:0] w);
        instr_valid = v;
        instr = w;
        @(posedge clk);
        model_apply(v, w);
        @(negedge clk);
        compare_all();
    endtask

    task automatic read_reg(input int r, output int a, output int b);
        sel = 5'(r);
        #1;
        a = int'(rd_a);
        b = int'(rd_b);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        instr_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int a, b, pc0, sr0;
        @(negedge clk);
        do_reset();

        // R11: reset state
        chk(pc_a == 16'h0, "R11 pc after reset", int'(pc_a), 0);
        chk(sr_a == 8'h00, "R11 status after reset", int'(sr_a), 0);
        chk(sr_b == 8'hE1, "R11 preset status after reset", int'(sr_b), 8'hE1);
        for (int i = 0; i < 32; i++) begin
            read_reg(i, a, b);
            chk(a == 0, "R11 register cleared", a, 0);
        end

        // R2 R6: count r17 from 0x00 down to 0x10, then to zero
        for (int i = 0; i < 240; i++) step(1'b1, dec_op(17));
        read_reg(17, a, b);
        chk(a == 8'h10, "R2 wrap to 0x10", a, 8'h10);
        for (int i = 0; i < 15; i++) step(1'b1, dec_op(17));
        chk(sr_a[1] == 1'b0, "R6 Z clear at 0x01", int'(sr_a[1]), 0);
        step(1'b1, dec_op(17));
        read_reg(17, a, b);
        chk(a == 0, "R6 counter reached zero", a, 0);
        chk(sr_a[1] == 1'b1, "R6 Z set on last step", int'(sr_a[1]), 1);
        chk(sr_a[0] == 1'b0, "R3 C kept at 0", int'(sr_a[0]), 0);
        chk(sr_b[0] == 1'b1, "R3 C kept at 1", int'(sr_b[0]), 1);
        chk(sr_b[7:5] == 3'b111, "R3 I/T/H kept", int'(sr_b[7:5]), 7);

        // R4 R7: 0x80 -> 0x7F
        for (int i = 0; i < 128; i++) step(1'b1, dec_op(3));
        read_reg(3, a, b);
        chk(a == 8'h80, "R2 reached 0x80", a, 8'h80);
        chk(sr_a[3] == 1'b0, "R4 V clear before 0x80 step", int'(sr_a[3]), 0);
        step(1'b1, dec_op(3));
        read_reg(3, a, b);
        chk(a == 8'h7F, "R2 0x80 to 0x7F", a, 8'h7F);
        chk(sr_a[3] == 1'b1, "R4 V set", int'(sr_a[3]), 1);
        chk(sr_a[4] == 1'b1, "R7 S set", int'(sr_a[4]), 1);
        chk(sr_a[2] == 1'b0, "R5 N clear", int'(sr_a[2]), 0);
        chk(sr_b[0] == 1'b1, "R3 C kept at 1 on overflow", int'(sr_b[0]), 1);

        // R5: 0x00 -> 0xFF
        step(1'b1, dec_op(0));
        read_reg(0, a, b);
        chk(a == 8'hFF, "R2 0x00 to 0xFF", a, 8'hFF);
        chk(sr_a[2] == 1'b1, "R5 N set", int'(sr_a[2]), 1);
        chk(sr_a[3] == 1'b0, "R4 V clear", int'(sr_a[3]), 0);
        chk(sr_a[4] == 1'b1, "R7 S equals N", int'(sr_a[4]), 1);

        // R1: only the addressed register changes
        step(1'b1, dec_op(31));
        read_reg(31, a, b);
        chk(a == 8'hFF, "R1 r31 written", a, 8'hFF);
        read_reg(30, a, b);
        chk(a == 0, "R1 r30 untouched", a, 0);
        read_reg(0, a, b);
        chk(a == 8'hFF, "R1 r0 untouched", a, 8'hFF);

        // R9: near-miss and unrelated words
        sr0 = int'(sr_a);
        pc0 = int'(pc_a);
        step(1'b1, 16'h940B);
        step(1'b1, 16'h9C1A);
        step(1'b1, 16'h0000);
        read_reg(0, a, b);
        chk(a == 8'hFF, "R9 r0 unchanged by other words", a, 8'hFF);
        read_reg(1, a, b);
        chk(a == 0, "R9 r1 unchanged by other words", a, 0);
        chk(int'(sr_a) == sr0, "R9 status unchanged", int'(sr_a), sr0);
        chk(int'(pc_a) == pc0 + 3, "R8 pc advanced by other words", int'(pc_a), pc0 + 3);

        // R10: strobe low holds everything
        pc0 = int'(pc_a);
        for (int i = 0; i < 4; i++) step(1'b0, dec_op(0));
        read_reg(0, a, b);
        chk(a == 8'hFF, "R10 register held", a, 8'hFF);
        chk(int'(pc_a) == pc0, "R10 pc held", int'(pc_a), pc0);

        // R11: reset in the middle of a run
        do_reset();
        read_reg(3, a, b);
        chk(a == 0, "R11 register cleared again", a, 0);
        chk(pc_a == 16'h0, "R11 pc cleared again", int'(pc_a), 0);
        chk(sr_b == 8'hE1, "R11 preset status again", int'(sr_b), 8'hE1);
        step(1'b1, dec_op(5));
        read_reg(5, a, b);
        chk(b == 8'hFF, "R2 dut_c wrap", b, 8'hFF);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule